// File: doc/BRIEF.md
# Sparse-Space PCI Address Translator

This block sits on the host side of a processor-to-PCI bridge. Each cycle in which a request strobe is raised, it takes a 40-bit processor physical address and decodes it. It reports which address space the access falls in and which of four bridge instances it targets. For the two sparse spaces, memory and I/O, it also rebuilds the 32-bit PCI address and active-low byte enables. In those spaces the PCI offset is held shifted left by five inside the processor address. The transfer length and byte lane travel in the low processor address bits, and the top PCI address bits come from two software-loaded extension registers.

Malformed requests produce a one-cycle decode-error pulse instead of a PCI cycle. A request is malformed if it lies outside every defined space, or if it asks for a length and byte-offset pair that the lane table does not allow. A separate combinational path narrows returned 32-bit lane data to the width of the original access.

Top module: `pci_sparse_xlate`

## Requirements
- R1: Space decoding uses five tests, applied in order. If processor bits 39:35 are all ones and bit 32 is 0, the space is sparse memory (code 0). Otherwise, with bit 32 at 1, bit 31 at 0 gives dense (code 1). Bits 31:30 at 10 give I/O (code 2). Bits 31:29 at 110 give configuration (code 3). Bits 31:29 at 111 give CSR (code 4). The instance number equals bits 34:33.
- R2: An address whose bits 39:35 are not all ones produces dec_err_o high for exactly one cycle and no cyc_valid_o.
- R3: In sparse memory and I/O, bits 4:3 are the length code (00 byte, 01 word, 10 tribyte, 11 longword) and bits 6:5 the byte offset. A byte access at offsets 0..3 gives cyc_be_n_o 1110, 1101, 1011 and 0111.
- R4: A word at offset 0 gives 1100 and at offset 2 gives 0011. A tribyte at offset 0 gives 1000 and at offset 1 gives 0001. A longword at offset 2 gives 0000.
- R5: Any other length and offset pair in sparse memory or I/O (for example a word at offset 1) gives a decode-error pulse and no PCI cycle.
- R6: For sparse memory, PCI address bits 31:29 come from the memory extension register and bits 28:2 from processor bits 33:7. Bits 1:0 are zero.
- R7: For I/O, PCI address bits 31:25 come from the I/O extension register and bits 24:2 from processor bits 29:7. Bits 1:0 are zero.
- R8: For dense space the PCI address is processor bits 31:0. For configuration and CSR space it is processor bits 28:0, zero-extended. In all three spaces the byte enables are 0000.
- R9: Both extension registers reset to zero. A write at CSR offset 0x400 loads the memory register from write data bits 31:29, and a write at 0x440 loads the I/O register from bits 31:25. The new value first applies to a request in the cycle after the write strobe; a request in the same cycle sees the old value.
- R10: rd_data_o is rd_lane_i shifted right by 8 times rd_off_i. It is then zero-extended above byte 0, 1, 2 or 3 for length codes 00, 01, 10 and 11.
- R11: The cycle outputs and dec_err_o appear in the cycle after the request strobe. They are low in any cycle that does not follow a request, and low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 40 | Processor physical address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_off_i | input | 12 | CSR offset |
| csr_wdata_i | input | 32 | CSR write data |
| rd_lane_i | input | 32 | Returned 32-bit lane data |
| rd_off_i | input | 2 | Byte offset of the read |
| rd_len_i | input | 2 | Length code of the read |
| cyc_valid_o | output | 1 | Decoded PCI cycle present |
| cyc_space_o | output | 3 | Space code |
| cyc_hose_o | output | 2 | Bridge instance |
| cyc_addr_o | output | 32 | PCI address |
| cyc_be_n_o | output | 4 | Active-low byte enables |
| dec_err_o | output | 1 | Decode-error pulse |
| rd_data_o | output | 32 | Narrowed read data |

## Verification
The bench exercises every length and offset pair in the lane table and several pairs outside it. These include a word at offset 1 and a longword at offset 0. A design with a transposed table would either emit wrong enables or let an illegal pair through as a PCI cycle. The bench checks instance bit 33 together with the sparse offset it shares. It also checks the space boundaries at bits 31:29, where an off-by-one bit would move an I/O access into configuration space. It probes extension register timing with a request issued in the same cycle as the write and another issued one cycle later. A design that bypassed the write, or delayed it an extra cycle, would put the wrong upper bits on one of the two.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;
  localparam int PA_W      = 40;
  localparam int PCI_W     = 32;
  localparam int HOSE_W    = 2;
  localparam int BE_W      = PCI_W / 8;
  localparam int LANE_W    = $clog2(BE_W);
  localparam int HAE_MEM_W = 3;
  localparam int HAE_IO_W  = 7;
  localparam int CSR_OFF_W = 12;
  localparam int SPARSE_SH = 7;

  localparam logic [CSR_OFF_W-1:0] CSR_HAE_MEM = 12'h400;
  localparam logic [CSR_OFF_W-1:0] CSR_HAE_IO  = 12'h440;

  typedef enum logic [2:0] {
    SP_SPARSE = 3'd0,
    SP_DENSE  = 3'd1,
    SP_IO     = 3'd2,
    SP_CFG    = 3'd3,
    SP_CSR    = 3'd4
  } space_e;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'b00,
    LEN_WORD = 2'b01,
    LEN_TRI  = 2'b10,
    LEN_LONG = 2'b11
  } len_e;
endpackage

// File: rtl/pci_xlate_space_dec.sv
module pci_xlate_space_dec
  import pci_xlate_pkg::*;
(
  input  logic [PA_W-1:0]   addr_i,
  output logic              hit_o,
  output space_e            space_o,
  output logic [HOSE_W-1:0] hose_o
);
  logic window_ok;

  assign window_ok = &addr_i[PA_W-1:35];
  assign hose_o    = addr_i[34:33];

  always_comb begin
    hit_o   = window_ok;
    space_o = SP_SPARSE;
    if (!addr_i[32])       space_o = SP_SPARSE;
    else if (!addr_i[31])  space_o = SP_DENSE;
    else if (!addr_i[30])  space_o = SP_IO;
    else if (!addr_i[29])  space_o = SP_CFG;
    else                   space_o = SP_CSR;
  end
endmodule

// File: rtl/pci_xlate_lane_dec.sv
module pci_xlate_lane_dec
  import pci_xlate_pkg::*;
(
  input  logic [1:0]        len_i,
  input  logic [LANE_W-1:0] off_i,
  output logic [BE_W-1:0]   be_n_o,
  output logic              ok_o
);
  always_comb begin
    be_n_o = '1;
    ok_o   = 1'b1;
    unique case (len_e'(len_i))
      LEN_BYTE: be_n_o = ~(BE_W'(1) << off_i);
      LEN_WORD: begin
        if (off_i == 2'd0)      be_n_o = 4'b1100;
        else if (off_i == 2'd2) be_n_o = 4'b0011;
        else                    ok_o   = 1'b0;
      end
      LEN_TRI: begin
        if (off_i == 2'd0)      be_n_o = 4'b1000;
        else if (off_i == 2'd1) be_n_o = 4'b0001;
        else                    ok_o   = 1'b0;
      end
      LEN_LONG: begin
        if (off_i == 2'd2)      be_n_o = 4'b0000;
        else                    ok_o   = 1'b0;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pci_xlate_hae_regs.sv
module pci_xlate_hae_regs
  import pci_xlate_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CSR_OFF_W-1:0] off_i,
  input  logic [PCI_W-1:0]     wdata_i,
  output logic [HAE_MEM_W-1:0] hae_mem_o,
  output logic [HAE_IO_W-1:0]  hae_io_o
);
  logic [PCI_W-HAE_IO_W-1:0] unused_wdata;
  assign unused_wdata = wdata_i[PCI_W-HAE_IO_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hae_mem_o <= '0;
      hae_io_o  <= '0;
    end else if (we_i) begin
      if (off_i == CSR_HAE_MEM) hae_mem_o <= wdata_i[PCI_W-1 -: HAE_MEM_W];
      if (off_i == CSR_HAE_IO)  hae_io_o  <= wdata_i[PCI_W-1 -: HAE_IO_W];
    end
  end
endmodule

// File: rtl/pci_xlate_rd_steer.sv
module pci_xlate_rd_steer #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int SEL_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] lane_i,
  input  logic [SEL_W-1:0]  off_i,
  input  logic [SEL_W-1:0]  len_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shifted;
  assign shifted = lane_i >> {off_i, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [SEL_W-1:0] LI = SEL_W'(i);
    assign data_o[8*i +: 8] = (LI <= len_i) ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/pci_sparse_xlate.sv
module pci_sparse_xlate
  import pci_xlate_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [PA_W-1:0]      req_addr_i,
  input  logic                 csr_we_i,
  input  logic [CSR_OFF_W-1:0] csr_off_i,
  input  logic [PCI_W-1:0]     csr_wdata_i,
  input  logic [PCI_W-1:0]     rd_lane_i,
  input  logic [LANE_W-1:0]    rd_off_i,
  input  logic [LANE_W-1:0]    rd_len_i,
  output logic                 cyc_valid_o,
  output logic [2:0]           cyc_space_o,
  output logic [HOSE_W-1:0]    cyc_hose_o,
  output logic [PCI_W-1:0]     cyc_addr_o,
  output logic [BE_W-1:0]      cyc_be_n_o,
  output logic                 dec_err_o,
  output logic [PCI_W-1:0]     rd_data_o
);
  logic                 hit;
  space_e               space;
  logic [HOSE_W-1:0]    hose;
  logic [BE_W-1:0]      lane_be_n;
  logic                 lane_ok;
  logic [HAE_MEM_W-1:0] hae_mem;
  logic [HAE_IO_W-1:0]  hae_io;
  logic                 sparse_kind;
  logic                 legal;
  logic [PCI_W-1:0]     pci_addr_d;
  logic [BE_W-1:0]      be_n_d;
  logic [2:0]           unused_addr;

  assign unused_addr = req_addr_i[2:0];

  pci_xlate_space_dec u_space (
    .addr_i  (req_addr_i),
    .hit_o   (hit),
    .space_o (space),
    .hose_o  (hose)
  );

  pci_xlate_lane_dec u_lane (
    .len_i  (req_addr_i[4:3]),
    .off_i  (req_addr_i[6:5]),
    .be_n_o (lane_be_n),
    .ok_o   (lane_ok)
  );

  pci_xlate_hae_regs u_hae (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (csr_we_i),
    .off_i     (csr_off_i),
    .wdata_i   (csr_wdata_i),
    .hae_mem_o (hae_mem),
    .hae_io_o  (hae_io)
  );

  pci_xlate_rd_steer #(.DATA_W(PCI_W)) u_steer (
    .lane_i (rd_lane_i),
    .off_i  (rd_off_i),
    .len_i  (rd_len_i),
    .data_o (rd_data_o)
  );

  assign sparse_kind = (space == SP_SPARSE) || (space == SP_IO);
  assign legal       = hit && (!sparse_kind || lane_ok);

  always_comb begin
    be_n_d = sparse_kind ? lane_be_n : '0;
    unique case (space)
      SP_SPARSE: pci_addr_d = {hae_mem, req_addr_i[33:SPARSE_SH], 2'b00};
      SP_IO:     pci_addr_d = {hae_io, req_addr_i[29:SPARSE_SH], 2'b00};
      SP_DENSE:  pci_addr_d = req_addr_i[PCI_W-1:0];
      default:   pci_addr_d = {3'b000, req_addr_i[28:0]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_valid_o <= 1'b0;
      dec_err_o   <= 1'b0;
      cyc_space_o <= '0;
      cyc_hose_o  <= '0;
      cyc_addr_o  <= '0;
      cyc_be_n_o  <= '0;
    end else begin
      cyc_valid_o <= req_valid_i && legal;
      dec_err_o   <= req_valid_i && !legal;
      if (req_valid_i && legal) begin
        cyc_space_o <= space;
        cyc_hose_o  <= hose;
        cyc_addr_o  <= pci_addr_d;
        cyc_be_n_o  <= be_n_d;
      end
    end
  end
endmodule

// File: rtl/pci_xlate_chk.sv
module pci_xlate_chk
  import pci_xlate_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [PA_W-1:0]   req_addr_i,
  input logic              cyc_valid_o,
  input logic [2:0]        cyc_space_o,
  input logic [BE_W-1:0]   cyc_be_n_o,
  input logic              dec_err_o
);
  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cyc_valid_o, dec_err_o}));

  assert_follow_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o || dec_err_o) |-> $past(req_valid_i));

  assert_bad_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(&req_addr_i[PA_W-1:35])) |=> dec_err_o);

  assert_space_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> (cyc_space_o <= 3'd4));

  assert_sparse_be_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && (cyc_space_o == 3'd0 || cyc_space_o == 3'd2)) |-> (cyc_be_n_o != 4'hF));

  assert_plain_be_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && (cyc_space_o == 3'd1 || cyc_space_o == 3'd3 || cyc_space_o == 3'd4))
      |-> (cyc_be_n_o == 4'h0));
endmodule

bind pci_sparse_xlate pci_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .cyc_valid_o (cyc_valid_o),
  .cyc_space_o (cyc_space_o),
  .cyc_be_n_o  (cyc_be_n_o),
  .dec_err_o   (dec_err_o)
);

// File: tb/pci_sparse_xlate_test.sv
`timescale 1ns/1ps
module pci_sparse_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_off = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] rd_lane = '0;
  logic [1:0]  rd_off = '0;
  logic [1:0]  rd_len = '0;
  logic        cyc_valid;
  logic [2:0]  cyc_space;
  logic [1:0]  cyc_hose;
  logic [31:0] cyc_addr;
  logic [3:0]  cyc_be_n;
  logic        dec_err;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  pci_sparse_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .csr_we_i(csr_we), .csr_off_i(csr_off), .csr_wdata_i(csr_wdata),
    .rd_lane_i(rd_lane), .rd_off_i(rd_off), .rd_len_i(rd_len),
    .cyc_valid_o(cyc_valid), .cyc_space_o(cyc_space), .cyc_hose_o(cyc_hose),
    .cyc_addr_o(cyc_addr), .cyc_be_n_o(cyc_be_n), .dec_err_o(dec_err), .rd_data_o(rd_data)
  );

  typedef struct {
    logic        err;
    logic [2:0]  sp;
    logic [1:0]  hose;
    logic [31:0] a;
    logic [3:0]  be;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;
  logic [2:0]  m_hm = '0;
  logic [6:0]  m_hi = '0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [39:0] a, input string tag);
    exp_t e;
    e.err = 1'b0; e.tag = tag; e.be = 4'h0; e.hose = a[34:33];
    if (a[39:35] != 5'h1F) e.err = 1'b1;
    if (!a[32])      e.sp = 3'd0;
    else if (!a[31]) e.sp = 3'd1;
    else if (!a[30]) e.sp = 3'd2;
    else if (!a[29]) e.sp = 3'd3;
    else             e.sp = 3'd4;
    case (e.sp)
      3'd0:    e.a = {m_hm, a[33:7], 2'b00};
      3'd2:    e.a = {m_hi, a[29:7], 2'b00};
      3'd1:    e.a = a[31:0];
      default: e.a = {3'b000, a[28:0]};
    endcase
    if (e.sp == 3'd0 || e.sp == 3'd2) begin
      case ({a[4:3], a[6:5]})
        4'b0000: e.be = 4'b1110;
        4'b0001: e.be = 4'b1101;
        4'b0010: e.be = 4'b1011;
        4'b0011: e.be = 4'b0111;
        4'b0100: e.be = 4'b1100;
        4'b0110: e.be = 4'b0011;
        4'b1000: e.be = 4'b1000;
        4'b1001: e.be = 4'b0001;
        4'b1110: e.be = 4'b0000;
        default: e.err = 1'b1;
      endcase
    end
    return e;
  endfunction

  function automatic logic [39:0] sp_a(input logic [1:0] h, input logic [26:0] off, input logic [1:0] len, input logic [1:0] b);
    return 40'hF8_0000_0000 | (40'(h) << 33) | (40'(off) << 7) | (40'(b) << 5) | (40'(len) << 3);
  endfunction

  function automatic logic [39:0] io_a(input logic [1:0] h, input logic [22:0] off, input logic [1:0] len, input logic [1:0] b);
    return 40'hF9_8000_0000 | (40'(h) << 33) | (40'(off) << 7) | (40'(b) << 5) | (40'(len) << 3);
  endfunction

  task automatic send(input logic [39:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    sb.push_back(model(a, tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic csr_apply(input logic [11:0] off, input logic [31:0] d);
    if (off == 12'h400) m_hm = d[31:29];
    if (off == 12'h440) m_hi = d[31:25];
  endtask

  task automatic csr_wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_off = off; csr_wdata = d;
    csr_apply(off, d);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic send_with_wr(input logic [39:0] a, input logic [11:0] off, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    csr_we = 1'b1; csr_off = off; csr_wdata = d;
    sb.push_back(model(a, tag));
    csr_apply(off, d);
    @(negedge clk);
    req_valid = 1'b0; csr_we = 1'b0;
  endtask

  task automatic steer(input logic [31:0] d, input logic [1:0] o, input logic [1:0] l, input logic [31:0] exp);
    @(negedge clk);
    rd_lane = d; rd_off = o; rd_len = l;
    #1;
    chk(rd_data == exp, "R10 read steering", 64'(rd_data), 64'(exp));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && (cyc_valid || dec_err)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 output without request", {cyc_valid, dec_err}, 2'b00);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.err)
          chk(dec_err && !cyc_valid, e.tag, {cyc_valid, dec_err}, 2'b01);
        else
          chk(cyc_valid && !dec_err && cyc_space == e.sp && cyc_hose == e.hose &&
              cyc_addr == e.a && cyc_be_n == e.be, e.tag,
              {cyc_valid, dec_err, cyc_space, cyc_hose, cyc_addr, cyc_be_n},
              {1'b1, 1'b0, e.sp, e.hose, e.a, e.be});
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cyc_valid && !dec_err && cyc_addr == 0, "R11 reset outputs", {cyc_valid, dec_err, cyc_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cyc_valid && !dec_err, "R11 idle after reset", {cyc_valid, dec_err}, 0);

    // R9 reset value of memory extension: top bits zero
    send(sp_a(2'd0, 27'h123_4567, 2'b00, 2'd0), "R9 R6 sparse byte off0 hae reset");
    for (int b = 0; b < 4; b++)
      send(sp_a(2'(b), 27'h000_0ABC + 27'(b), 2'b00, 2'(b)), "R3 R1 sparse byte lanes and hose");
    send(sp_a(2'd1, 27'h7FF_FFFF, 2'b01, 2'd0), "R4 word off0, hose bit33 shared");
    send(sp_a(2'd0, 27'h15, 2'b01, 2'd2), "R4 word off2");
    send(sp_a(2'd0, 27'h15, 2'b10, 2'd0), "R4 tribyte off0");
    send(sp_a(2'd3, 27'h15, 2'b10, 2'd1), "R4 tribyte off1");
    send(sp_a(2'd2, 27'h15, 2'b11, 2'd2), "R4 longword off2");
    send(sp_a(2'd0, 27'h15, 2'b01, 2'd1), "R5 word off1 illegal");
    send(sp_a(2'd0, 27'h15, 2'b01, 2'd3), "R5 word off3 illegal");
    send(sp_a(2'd0, 27'h15, 2'b10, 2'd2), "R5 tribyte off2 illegal");
    send(sp_a(2'd0, 27'h15, 2'b11, 2'd0), "R5 longword off0 illegal");
    send(io_a(2'd1, 23'h12_3456, 2'b00, 2'd3), "R7 io byte hae reset");
    send(io_a(2'd0, 23'h1, 2'b11, 2'd1), "R5 io longword off1 illegal");

    // R9 same-cycle write uses old value, next request uses new
    send_with_wr(sp_a(2'd0, 27'h40, 2'b00, 2'd1), 12'h400, 32'hA000_0000, "R9 same-cycle old hae_mem");
    send(sp_a(2'd0, 27'h40, 2'b00, 2'd1), "R9 R6 new hae_mem");
    csr_wr(12'h440, 32'hFE00_0000);
    send(io_a(2'd2, 23'h7F_FFFF, 2'b01, 2'd2), "R9 R7 new hae_io");
    csr_wr(12'h480, 32'hFFFF_FFFF);
    send(sp_a(2'd3, 27'h1, 2'b00, 2'd0), "R9 other offset ignored");

    send(40'hF9_1234_5678, "R8 R1 dense");
    send(40'hFD_7000_0004, "R8 R1 dense hose2");
    send(40'hF9_C001_2345, "R8 R1 config");
    send(40'hFF_E000_0400, "R8 R1 csr space hose3");
    send(40'hF9_BFFF_FFE0, "R1 io upper boundary");
    send(40'h70_0000_0000, "R2 no bit39");
    send(40'hF0_0000_0000, "R2 window miss");
    // back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 40'hF9_0000_0010; sb.push_back(model(req_addr, "R11 back-to-back a"));
    @(negedge clk);
    req_addr = 40'h00_0000_0000; sb.push_back(model(req_addr, "R11 back-to-back b err"));
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 all results seen", 64'(sb.size()), 0);
    chk(!dec_err && !cyc_valid, "R2 pulse one cycle", {cyc_valid, dec_err}, 0);

    steer(32'hAABB_CCDD, 2'd1, 2'b00, 32'h0000_00CC);
    steer(32'hAABB_CCDD, 2'd2, 2'b01, 32'h0000_AABB);
    steer(32'hAABB_CCDD, 2'd0, 2'b11, 32'hAABB_CCDD);
    steer(32'hAABB_CCDD, 2'd1, 2'b10, 32'h00AA_BBCC);
    steer(32'h1122_3344, 2'd3, 2'b00, 32'h0000_0011);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule